// File: doc/BRIEF.md
# Odd-Even Adaptive Route Computation

This block computes the output port for one router of a two-dimensional mesh network-on-chip. For each packet header it is given the coordinates of the router it sits in, of the router where the packet was injected, and of the router the packet is headed to. From the signed column and row offsets it builds the set of directions that both move the packet closer to its target and obey the odd-even turn model. That model bans an eastbound packet from turning north or south in an even column. It also bans a packet travelling north or south from turning west in an odd column. Because no cycle of turns can form, the mesh stays free of routing deadlock while still offering adaptive choices.

When the legal set holds a horizontal and a vertical candidate, the block picks the one whose downstream neighbour advertises more free credits. Equal credits go to the horizontal candidate. The chosen port is registered as a one-hot request. It is held for the body and tail flits until the surrounding router reports that the tail flit has left. While a port is held, the block does not accept a new header.

Top module: `oe_route_unit`

## Requirements
- R1: When the destination equals the current router, the request is the Local port. The port encoding is bit 0 East, bit 1 West, bit 2 North, bit 3 South, bit 4 Local.
- R2: When the column offset is zero and the row offset is not, the request is North for a positive row offset and South for a negative one. No other direction is allowed.
- R3: When the row offset is zero and the column offset is not, the only allowed direction is East for a positive column offset and West for a negative one.
- R4: For an eastbound packet with a nonzero row offset, the vertical direction is allowed only if the current column is odd or equals the source column.
- R5: For an eastbound packet with a nonzero row offset, East is allowed only if the destination column is odd or the column offset differs from 1.
- R6: For a westbound packet with a nonzero row offset, West is always allowed. The vertical direction is allowed as well only if the current column is even.
- R7: When both a horizontal and a vertical direction are allowed, the one with the larger downstream credit count is chosen. Equal counts choose the horizontal direction.
- R8: A header is accepted on a clock edge where hdrValid and hdrReady are both high. From the next cycle, reqValid is high and portReq carries exactly one set bit. While reqValid is low, portReq is zero.
- R9: While reqValid is high, portReq stays constant, hdrReady is low and new headers are ignored. A tailSent pulse clears reqValid on the next edge and raises hdrReady again. A tailSent pulse with no port held has no effect.
- R10: After reset, reqValid is low, portReq is zero and hdrReady is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| curX | input | XW | Column of this router |
| curY | input | YW | Row of this router |
| srcX | input | XW | Column of the packet's injecting router |
| srcY | input | YW | Row of the packet's injecting router |
| dstX | input | XW | Column of the destination router |
| dstY | input | YW | Row of the destination router |
| credE | input | CRED_W | Free credits toward East |
| credW | input | CRED_W | Free credits toward West |
| credN | input | CRED_W | Free credits toward North |
| credS | input | CRED_W | Free credits toward South |
| hdrValid | input | 1 | Header flit with coordinates present |
| hdrReady | output | 1 | Block can accept a header |
| tailSent | input | 1 | Tail flit of the held packet has left |
| reqValid | output | 1 | portReq is valid and held |
| portReq | output | 5 | One-hot output port request |

## Verification
The port choice is due one cycle after the accepting edge, because it passes through a single register. The bench drives a header on a falling edge, lets one rising edge pass and reads portReq and reqValid on the following falling edge. The credits and coordinates are held steady across that accepting edge, since the selection reads them then. The release is due one cycle after a tailSent pulse, so the bench reads reqValid and hdrReady on the falling edge that follows the next rising edge. Any header offered while a port is held is checked one cycle later against the port that was already latched.

// File: rtl/oe_route_pkg.sv
package oe_route_pkg;

  // Index of each direction inside the one-hot port vector
  localparam int DIR_E = 0;
  localparam int DIR_W = 1;
  localparam int DIR_N = 2;
  localparam int DIR_S = 3;
  localparam int DIR_L = 4;
  localparam int NUM_DIR = 5;

  typedef logic [NUM_DIR-1:0] portVec_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // latch the computed port
    logic clear;  // drop the held port
  } ctrlStrobe_t;

endpackage

// File: rtl/oe_route_dp.sv
module oe_route_dp
  import oe_route_pkg::*;
#(
  parameter int XW     = 3,
  parameter int YW     = 3,
  parameter int CRED_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [XW-1:0]     curX,
  input  logic [YW-1:0]     curY,
  input  logic [XW-1:0]     srcX,
  input  logic [XW-1:0]     dstX,
  input  logic [YW-1:0]     dstY,
  input  logic [CRED_W-1:0] credE,
  input  logic [CRED_W-1:0] credW,
  input  logic [CRED_W-1:0] credN,
  input  logic [CRED_W-1:0] credS,
  input  ctrlStrobe_t       strobe,
  output portVec_t          portReq
);

  // Signed offsets, one bit wider than the coordinates
  logic signed [XW:0] offX;
  logic signed [YW:0] offY;
  logic xZero, yZero, goEast, goSouth;
  logic curOdd, dstOdd, atSrcCol, offXIsOne;

  assign offX      = $signed({1'b0, dstX}) - $signed({1'b0, curX});
  assign offY      = $signed({1'b0, dstY}) - $signed({1'b0, curY});
  assign xZero     = (offX == '0);
  assign yZero     = (offY == '0);
  assign goEast    = (offX > 0);
  assign goSouth   = (offY < 0);
  assign curOdd    = curX[0];
  assign dstOdd    = dstX[0];
  assign atSrcCol  = (curX == srcX);
  assign offXIsOne = (offX == 1);

  // Legal direction set under the odd-even turn model
  logic allowHoriz, allowVert, allowLocal;

  always_comb begin
    allowHoriz = 1'b0;
    allowVert  = 1'b0;
    allowLocal = 1'b0;
    if (xZero && yZero) begin
      allowLocal = 1'b1;
    end else if (xZero) begin
      allowVert = 1'b1;
    end else if (yZero) begin
      allowHoriz = 1'b1;
    end else if (goEast) begin
      // turning off an eastward run is barred in even columns
      allowVert  = curOdd || atSrcCol;
      // last eastward hop must land in an odd column to turn there
      allowHoriz = dstOdd || !offXIsOne;
    end else begin
      // turning west is barred in odd columns, so turn before it
      allowHoriz = 1'b1;
      allowVert  = !curOdd;
    end
  end

  // Selection between horizontal and vertical candidates
  logic [CRED_W-1:0] credHoriz, credVert;
  logic              pickVert;
  portVec_t          nextPort;

  assign credHoriz = goEast  ? credE : credW;
  assign credVert  = goSouth ? credS : credN;

  always_comb begin
    if (allowHoriz && allowVert) pickVert = (credVert > credHoriz);
    else                         pickVert = allowVert;
  end

  always_comb begin
    nextPort = '0;
    if (allowLocal)       nextPort[DIR_L] = 1'b1;
    else if (pickVert)    nextPort[goSouth ? DIR_S : DIR_N] = 1'b1;
    else if (allowHoriz)  nextPort[goEast ? DIR_E : DIR_W] = 1'b1;
  end

  portVec_t portReg;

  always_ff @(posedge clk) begin
    if (!rstN)             portReg <= '0;
    else if (strobe.load)  portReg <= nextPort;
    else if (strobe.clear) portReg <= '0;
  end

  assign portReq = portReg;

endmodule

// File: rtl/oe_route_ctrl.sv
module oe_route_ctrl
  import oe_route_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        hdrValid,
  input  logic        tailSent,
  output logic        hdrReady,
  output logic        reqValid,
  output ctrlStrobe_t strobe
);

  typedef enum logic {ST_IDLE, ST_HOLD} state_t;
  state_t state, stateNext;

  always_comb begin
    stateNext    = state;
    strobe.load  = 1'b0;
    strobe.clear = 1'b0;
    unique case (state)
      ST_IDLE: if (hdrValid) begin
        strobe.load = 1'b1;
        stateNext   = ST_HOLD;
      end
      ST_HOLD: if (tailSent) begin
        strobe.clear = 1'b1;
        stateNext    = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign hdrReady = (state == ST_IDLE);
  assign reqValid = (state == ST_HOLD);

endmodule

// File: rtl/oe_route_unit.sv
module oe_route_unit
  import oe_route_pkg::*;
#(
  parameter int MESH_W = 8,
  parameter int MESH_H = 8,
  parameter int CRED_W = 4,
  localparam int XW = (MESH_W > 1) ? $clog2(MESH_W) : 1,
  localparam int YW = (MESH_H > 1) ? $clog2(MESH_H) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [XW-1:0]     curX,
  input  logic [YW-1:0]     curY,
  input  logic [XW-1:0]     srcX,
  input  logic [YW-1:0]     srcY,
  input  logic [XW-1:0]     dstX,
  input  logic [YW-1:0]     dstY,
  input  logic [CRED_W-1:0] credE,
  input  logic [CRED_W-1:0] credW,
  input  logic [CRED_W-1:0] credN,
  input  logic [CRED_W-1:0] credS,
  input  logic              hdrValid,
  output logic              hdrReady,
  input  logic              tailSent,
  output logic              reqValid,
  output logic [4:0]        portReq
);

  ctrlStrobe_t strobe;
  logic        srcYUnused;

  // The source row does not enter any odd-even rule
  assign srcYUnused = ^srcY;

  oe_route_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .hdrValid (hdrValid),
    .tailSent (tailSent),
    .hdrReady (hdrReady),
    .reqValid (reqValid),
    .strobe   (strobe)
  );

  oe_route_dp #(
    .XW     (XW),
    .YW     (YW),
    .CRED_W (CRED_W)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .curX    (curX),
    .curY    (curY),
    .srcX    (srcX),
    .dstX    (dstX),
    .dstY    (dstY),
    .credE   (credE),
    .credW   (credW),
    .credN   (credN),
    .credS   (credS),
    .strobe  (strobe),
    .portReq (portReq)
  );

endmodule

// File: rtl/oe_route_chk.sv
module oe_route_chk #(
  parameter int XW = 3,
  parameter int YW = 3
) (
  input logic          clk,
  input logic          rstN,
  input logic [XW-1:0] curX,
  input logic [YW-1:0] curY,
  input logic [XW-1:0] dstX,
  input logic [YW-1:0] dstY,
  input logic          hdrValid,
  input logic          hdrReady,
  input logic          tailSent,
  input logic          reqValid,
  input logic [4:0]    portReq
);

  p_local_r1: assert property (@(posedge clk) disable iff (!rstN)
    (hdrValid && hdrReady && dstX == curX && dstY == curY) |=> portReq == 5'b10000);

  p_same_row_r3: assert property (@(posedge clk) disable iff (!rstN)
    (hdrValid && hdrReady && dstY == curY && dstX > curX) |=> portReq == 5'b00001);

  p_accept_r8: assert property (@(posedge clk) disable iff (!rstN)
    (hdrValid && hdrReady) |=> (reqValid && $countones(portReq) == 1));

  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> portReq == 5'b0);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !tailSent) |=> (reqValid && $stable(portReq) && !hdrReady));

  p_release_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && tailSent) |=> (!reqValid && hdrReady));

endmodule

bind oe_route_unit oe_route_chk #(.XW(XW), .YW(YW)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .curX     (curX),
  .curY     (curY),
  .dstX     (dstX),
  .dstY     (dstY),
  .hdrValid (hdrValid),
  .hdrReady (hdrReady),
  .tailSent (tailSent),
  .reqValid (reqValid),
  .portReq  (portReq)
);

// File: tb/tb_oe_route_unit.sv
module tb_oe_route_unit;

  localparam logic [4:0] P_E = 5'b00001;
  localparam logic [4:0] P_W = 5'b00010;
  localparam logic [4:0] P_N = 5'b00100;
  localparam logic [4:0] P_S = 5'b01000;
  localparam logic [4:0] P_L = 5'b10000;

  logic       clk = 1'b0;
  logic       rstN;
  logic [2:0] curX, curY, srcX, srcY, dstX, dstY;
  logic [3:0] credE, credW, credN, credS;
  logic       hdrValid, tailSent;
  logic       hdrReady, reqValid;
  logic [4:0] portReq;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  oe_route_unit dut (
    .clk(clk), .rstN(rstN),
    .curX(curX), .curY(curY), .srcX(srcX), .srcY(srcY),
    .dstX(dstX), .dstY(dstY),
    .credE(credE), .credW(credW), .credN(credN), .credS(credS),
    .hdrValid(hdrValid), .hdrReady(hdrReady),
    .tailSent(tailSent), .reqValid(reqValid), .portReq(portReq)
  );

  task automatic check(input string tag, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic setCoords(input int cx, input int cy, input int sx, input int sy,
                           input int dx, input int dy);
    curX = 3'(cx); curY = 3'(cy); srcX = 3'(sx); srcY = 3'(sy);
    dstX = 3'(dx); dstY = 3'(dy);
  endtask

  task automatic setCred(input int e, input int w, input int n, input int s);
    credE = 4'(e); credW = 4'(w); credN = 4'(n); credS = 4'(s);
  endtask

  // Offer a header, check the latched port, then release with a tail
  task automatic routeOne(input string tag, input logic [4:0] exp);
    hdrValid = 1'b1;
    @(negedge clk);
    hdrValid = 1'b0;
    check(tag, {reqValid, hdrReady, portReq}, {1'b1, 1'b0, exp});
    tailSent = 1'b1;
    @(negedge clk);
    tailSent = 1'b0;
    check({tag, " release R9"}, {reqValid, hdrReady, portReq}, {1'b1 ^ 1'b1, 1'b1, 5'b0});
  endtask

  task automatic testReset();
    check("R10 reset state", {reqValid, hdrReady, portReq}, {1'b0, 1'b1, 5'b0});
  endtask

  task automatic testLocal();
    setCoords(3, 3, 0, 0, 3, 3); setCred(9, 9, 9, 9);
    routeOne("R1 local", P_L);
  endtask

  task automatic testColumn();
    setCoords(2, 2, 0, 0, 2, 5); setCred(15, 15, 0, 0);
    routeOne("R2 north", P_N);
    setCoords(2, 2, 0, 0, 2, 0);
    routeOne("R2 south", P_S);
  endtask

  task automatic testRow();
    setCoords(1, 4, 0, 0, 5, 4); setCred(0, 0, 15, 15);
    routeOne("R3 east same row", P_E);
    setCoords(4, 3, 6, 3, 0, 3);
    routeOne("R3 west same row", P_W);
  endtask

  task automatic testEastOddCol();
    setCoords(3, 1, 0, 0, 6, 5); setCred(5, 0, 9, 0);
    routeOne("R4 R7 odd col higher north", P_N);
    setCred(9, 0, 5, 0);
    routeOne("R7 higher east", P_E);
    setCred(7, 0, 7, 0);
    routeOne("R7 tie to east", P_E);
  endtask

  task automatic testEastEvenCol();
    setCoords(2, 1, 0, 1, 5, 4); setCred(1, 0, 15, 0);
    routeOne("R4 even col no turn", P_E);
    setCoords(2, 1, 2, 1, 5, 0); setCred(3, 0, 0, 12);
    routeOne("R4 source col may turn", P_S);
  endtask

  task automatic testLastHop();
    setCoords(3, 2, 1, 2, 4, 6); setCred(15, 0, 0, 0);
    routeOne("R5 even dest last hop", P_N);
    setCoords(4, 2, 4, 2, 5, 6); setCred(2, 0, 2, 0);
    routeOne("R5 odd dest last hop tie", P_E);
  endtask

  task automatic testWest();
    setCoords(5, 2, 7, 2, 1, 6); setCred(0, 0, 15, 0);
    routeOne("R6 odd col west only", P_W);
    setCoords(4, 6, 7, 6, 1, 2); setCred(0, 3, 0, 10);
    routeOne("R6 even col south", P_S);
    setCred(0, 6, 0, 6);
    routeOne("R6 R7 even col tie west", P_W);
  endtask

  task automatic testHold();
    tailSent = 1'b1;
    @(negedge clk);
    tailSent = 1'b0;
    check("R9 idle tail ignored", {reqValid, hdrReady, portReq}, {1'b0, 1'b1, 5'b0});
    setCoords(1, 4, 0, 0, 5, 4); setCred(4, 4, 4, 4);
    hdrValid = 1'b1;
    @(negedge clk);
    check("R8 accepted", {reqValid, hdrReady, portReq}, {1'b1, 1'b0, P_E});
    setCoords(3, 3, 0, 0, 3, 3);
    @(negedge clk);
    @(negedge clk);
    hdrValid = 1'b0;
    check("R9 header ignored while held", {reqValid, hdrReady, portReq}, {1'b1, 1'b0, P_E});
    tailSent = 1'b1;
    @(negedge clk);
    tailSent = 1'b0;
    check("R9 released", {reqValid, hdrReady, portReq}, {1'b0, 1'b1, 5'b0});
    routeOne("R9 next header after release", P_L);
  endtask

  initial begin
    rstN = 1'b0; hdrValid = 1'b0; tailSent = 1'b0;
    setCoords(0, 0, 0, 0, 0, 0); setCred(0, 0, 0, 0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testLocal();
    testColumn();
    testRow();
    testEastOddCol();
    testEastEvenCol();
    testLastHop();
    testWest();
    testHold();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R9 actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule